// File: doc/BRIEF.md
# DDS Sine Tone Sequencer

The block plays a four-note melody that repeats without end. Each note is a sine tone built by direct digital synthesis. A 32-bit phase register advances by a per-note step on every clock. Its top byte selects one of 256 entries in a built-in sine table, and the block sends that entry out as an unsigned 8-bit sample for a resistor-ladder DAC.

A dwell counter holds each note for a fixed number of clocks and then moves to the next note, starting the phase again from zero. A `mute` input stops playback while it is high. While muted, the block holds the note index, the dwell counter and the phase at zero. When `mute` falls, playback starts again from the beginning of the first note.

With the default parameters the clock is 25 MHz and each note lasts one second. The four steps give 440, 880, 1760 and 880 Hz, where step = 2^32 / f_clk × f_tone.

Top module: `dds_tone_seq`

## Requirements
- R1: While `rst` is high, `sample` is 127 at the next clock, and the melody starts from note 0 with phase 0.
- R2: While playing, the phase grows by the current note's step on every clock and wraps modulo 2^32.
- R3: `sample` is registered: it shows the table entry addressed by phase bits [31:24] as they stood one clock earlier.
- R4: Table entry i equals 127 + trunc(127·sin(2πi/256)), with truncation toward zero. This gives 0 at i=192, 127 at i=0 and i=128, and 254 at i=64.
- R5: Notes play in index order 0, 1, 2, 3 and then return to 0. The default steps are 75591, 151182, 302365 and 151182.
- R6: Each note lasts exactly `DWELL` clocks (default 25,000,000). On the clock that ends a note, the phase becomes 0 and the next note's step applies from the following clock.
- R7: While `mute` is high, the phase, dwell count and note index are held at zero, so `sample` settles at 127.
- R8: When `mute` falls in the middle of a note, playback restarts at note 0 with a full dwell, not at the interrupted note.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| mute | input | 1 | High stops playback and clears the sequence |
| sample | output | 8 | Unsigned sine sample for the DAC |

## Verification
Two things are hard to reach from the ports. One is a note change, which with the default parameters needs tens of millions of clocks. The other is that every table entry shows up at the output, which at audio steps takes a very long run. The bench therefore shrinks the dwell to a few hundred clocks. It sets the first note's step to exactly one table entry per clock, so all 256 entries appear in order, and gives the other notes distinct steps so that the note order and the phase restarts can be told apart. A mute pulse in the middle of a note then shows the full restart from note 0.

// File: rtl/dds_tone_seq.sv
module dds_tone_seq #(
  parameter int unsigned DWELL = 25_000_000,
  parameter logic [31:0] NOTE_INC [4] = '{32'd75591, 32'd151182, 32'd302365, 32'd151182}
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mute,
  output logic [7:0] sample
);
  localparam int DW = (DWELL > 2) ? $clog2(DWELL) : 1;
  localparam logic [DW-1:0] LAST = DW'(DWELL - 1);

  function automatic logic [7:0] sine_entry(input int idx);
    longint x, x2, term, acc, m;
    int j;
    bit neg;
    neg = idx >= 128;
    j = idx % 128;
    if (j > 64) j = 128 - j;
    if (j == 0) return 8'd127;
    if (j == 64) return neg ? 8'd0 : 8'd254;
    x = (64'sd3373259426 * longint'(j)) / 128;
    x2 = (x * x) >>> 30;
    term = x;
    acc = x;
    for (int k = 1; k < 13; k++) begin
      term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
      acc = acc + term;
    end
    m = (acc * 127) >>> 30;
    return neg ? 8'(127 - m) : 8'(127 + m);
  endfunction

  logic [7:0] lut [256];
  for (genvar i = 0; i < 256; i++) begin : g_lut
    localparam logic [7:0] V = sine_entry(i);
    assign lut[i] = V;
  end

  logic [31:0]   phase_q;
  logic [DW-1:0] dwell_q;
  logic [1:0]    note_q;
  logic          note_end;

  assign note_end = (dwell_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || mute) begin
      phase_q <= '0;
      dwell_q <= '0;
      note_q  <= '0;
    end else if (note_end) begin
      phase_q <= '0;
      dwell_q <= '0;
      note_q  <= note_q + 2'd1;
    end else begin
      phase_q <= phase_q + NOTE_INC[note_q];
      dwell_q <= dwell_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sample <= 8'd127;
    else     sample <= lut[phase_q[31:24]];
  end
endmodule

// File: rtl/dds_tone_seq_chk.sv
module dds_tone_seq_chk #(
  parameter int unsigned DWELL = 25_000_000,
  parameter logic [31:0] NOTE_INC [4] = '{32'd75591, 32'd151182, 32'd302365, 32'd151182},
  parameter int DW = 25
) (
  input logic          clk,
  input logic          rst,
  input logic          mute,
  input logic [7:0]    sample,
  input logic [31:0]   phase_q,
  input logic [DW-1:0] dwell_q,
  input logic [1:0]    note_q
);
  AST_MUTE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    mute |=> (phase_q == 32'd0 && dwell_q == '0 && note_q == 2'd0)); // R7

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!mute && dwell_q != DW'(DWELL - 1)) |=> (phase_q == $past(phase_q) + $past(NOTE_INC[note_q]))); // R2

  AST_NOTE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!mute && dwell_q == DW'(DWELL - 1)) |=> (note_q == $past(note_q) + 2'd1 && phase_q == 32'd0)); // R6

  AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (rst)
    dwell_q < DW'(DWELL)); // R6

  AST_SAMPLE_RANGE: assert property (@(posedge clk) disable iff (rst)
    sample <= 8'd254); // R4

  AST_MUTE_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
    (mute && $past(mute)) |=> sample == 8'd127); // R7
endmodule

bind dds_tone_seq dds_tone_seq_chk #(.DWELL(DWELL), .NOTE_INC(NOTE_INC), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mute(mute), .sample(sample),
  .phase_q(phase_q), .dwell_q(dwell_q), .note_q(note_q)
);

// File: tb/dds_tone_seq_tb.sv
module dds_tone_seq_tb;
  localparam int unsigned DWELL = 300;
  localparam logic [31:0] INC [4] = '{32'h0100_0000, 32'h0280_1234, 32'h0060_0ABC, 32'h0280_1234};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mute = 1'b0;
  logic [7:0] sample;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  dds_tone_seq #(.DWELL(DWELL), .NOTE_INC(INC)) u_dut (
    .clk(clk), .rst(rst), .mute(mute), .sample(sample)
  );

  logic [7:0]  tbl [256];
  logic [31:0] m_phase;
  int          m_dwell;
  logic [1:0]  m_note;
  logic [7:0]  m_sample;

  initial begin
    for (int i = 0; i < 256; i++)
      tbl[i] = 8'($rtoi($sin(2.0 * 3.141592653589793 * i / 256.0) * 127.0) + 127);
  end

  always @(posedge clk) begin
    if (rst || mute) begin
      m_phase <= 32'd0;
      m_dwell <= 0;
      m_note  <= 2'd0;
      m_sample <= rst ? 8'd127 : tbl[m_phase[31:24]];
    end else begin
      m_sample <= tbl[m_phase[31:24]];
      if (m_dwell == int'(DWELL) - 1) begin
        m_phase <= 32'd0;
        m_dwell <= 0;
        m_note  <= m_note + 2'd1;
      end else begin
        m_phase <= m_phase + INC[m_note];
        m_dwell <= m_dwell + 1;
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check(tag, sample, m_sample);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset sample", sample, 8'd127);
    check("R4 table peak", tbl[64], 8'd254);
    check("R4 table trough", tbl[192], 8'd0);
    rst = 1'b0;
    tag = "R2 R3 R4 sweep of every table entry";
    run(DWELL);
    tag = "R5 R6 note order and phase restart";
    run(4 * DWELL + 50);
    @(negedge clk);
    mute = 1'b1;
    tag = "R7 muted";
    run(3);
    check("R7 midscale while muted", sample, 8'd127);
    run(10);
    mute = 1'b0;
    tag = "R8 restart after mute";
    run(2 * DWELL);
    rst = 1'b1;
    tag = "R1 reset during play";
    run(3);
    check("R1 reset midscale", sample, 8'd127);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200_000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule